// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block models the status side of a parallel NOR flash array controller. It receives already-decoded commands on a valid/ready stream. The commands are program, sector erase, chip erase, erase suspend, erase resume and reset. It runs the embedded operation against a small on-chip word array and produces the two status flags that a host polls while the array is busy. The first is a sticky failure flag, raised when the internal pulse count passes its limit. The second is an erase-started flag, which stays low while the sector-erase acceptance window is still open.

A program can only clear bits. Each pulse ANDs the command data into the target word. When the data asks for a 1 where the word already holds a 0, the block keeps pulsing until the pulse limit is reached and then stops in a failed state that only a reset command leaves. A sector erase first opens an acceptance window, which is a cycle count. Each further sector erase that arrives inside the window adds its sector to the selection and restarts the full window. When the window closes, the erase begins. It then ignores everything except suspend and works through the selected sectors, lowest index first. Chip erase skips the window.

The command stream back-pressures only while a program operation is running: `cmd_ready` is low for that time and is high in every other state. A command is consumed on every cycle where `cmd_valid` and `cmd_ready` are both high, even if the current state discards it. The host must hold `cmd_op`, `cmd_addr` and `cmd_data` stable while `cmd_valid` is high and `cmd_ready` is low.

Top module: `flash_status_gen`

## Requirements
- R1: After reset every array word reads all ones, `busy`, `limit_fail`, `erase_started` and `sector_map` are 0, and `cmd_ready` is 1.
- R2: A program whose data sets no bit that the stored word has cleared finishes after PULSE_CYC cycles. `busy` then falls and the word reads back as old AND data.
- R3: A program that needs any stored 0 to become 1 pulses PULSE_LIMIT times. Exactly PULSE_LIMIT*PULSE_CYC cycles after acceptance, `limit_fail` rises and `busy` falls. The word then holds old AND data.
- R4: While `limit_fail` is 1, every command except reset is consumed with no effect on the array or the flags. A reset command clears `limit_fail` on the accepting edge and returns the block to idle.
- R5: A sector erase accepted in idle sets the sector's bit in `sector_map` (sector = address bits above log2(SECT_WORDS)) and raises `busy`. `erase_started` stays 0 until WINDOW_CYC cycles after acceptance and is 1 from that cycle on.
- R6: A sector erase accepted while the window is open adds its sector to `sector_map` and restarts the full WINDOW_CYC count from its own acceptance edge.
- R7: Once `erase_started` is 1 and `busy` is 1, every command except suspend is consumed with no effect. In particular, `sector_map` gains no bits and a program leaves the array unchanged.
- R8: The erase takes one selected sector every PULSE_CYC cycles, starting with the lowest index. Each such step sets all words of that sector to ones and clears its bit in `sector_map`. When the map becomes empty, `busy` and `erase_started` fall together.
- R9: A chip erase accepted in idle sets every bit of `sector_map` and raises `erase_started` on the accepting edge, with no window.
- R10: Suspend during an erase drops `busy`, keeps `erase_started` at 1, and freezes `sector_map` and the array. Resume continues the erase until the map is empty.
- R11: `cmd_op` is encoded as 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 reset. `cmd_ready` is 0 only while a program runs. Suspend, resume and reset in idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (see R11) |
| cmd_addr | input | ADDR_W | Word address (program) or any address in the sector (sector erase) |
| cmd_data | input | DATA_W | Program data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at `rd_addr` (combinational) |
| busy | output | 1 | Program, erase window or erase running |
| limit_fail | output | 1 | Pulse limit exceeded, sticky until reset command |
| erase_started | output | 1 | Erase running or suspended, acceptance window closed |
| sector_map | output | SECTORS | Sectors still selected for erase |

## Verification
A wrong operation state shows up on the flag pins on the first cycle after the faulty edge, because `busy`, `limit_fail`, `erase_started` and `cmd_ready` all decode straight from that state. A window or pulse counter that is off by one moves the rise of `erase_started` or `limit_fail`, or the clearing of a `sector_map` bit, by exactly one cycle. The bench therefore samples both sides of each of those edges. A wrong sector selection or write enable can stay invisible on the flags, so it is caught by reading back the array words of the erased and the untouched sectors.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_SERASE = 3'd1,
    OP_CERASE = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_RESET  = 3'd5
  } fsg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WIN,
    ST_ERASE,
    ST_SUSP,
    ST_FAIL
  } fsg_state_e;
endpackage

// File: rtl/fsg_win_timer.sv
module fsg_win_timer #(
  parameter int WINDOW_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= CW'(WINDOW_CYC);
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign expire = run && !load && (cnt_q == CW'(1));
endmodule

// File: rtl/fsg_pulse_timer.sv
module fsg_pulse_timer #(
  parameter int PULSE_CYC   = 16,
  parameter int PULSE_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick,
  output logic last
);
  localparam int CYC_W = $clog2(PULSE_CYC) + 1;
  localparam int NUM_W = $clog2(PULSE_LIMIT) + 1;
  logic [CYC_W-1:0] cyc_q;
  logic [NUM_W-1:0] num_q;

  assign tick = run && (cyc_q == CYC_W'(PULSE_CYC - 1));
  assign last = tick && (num_q == NUM_W'(PULSE_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      num_q <= '0;
    end else if (clear) begin
      cyc_q <= '0;
      num_q <= '0;
    end else if (tick) begin
      cyc_q <= '0;
      num_q <= num_q + NUM_W'(1);
    end else if (run) begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end
endmodule

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int DATA_W     = 8,
  parameter int SECTORS    = 4,
  parameter int SECT_WORDS = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_en,
  input  logic [SECTORS-1:0] erase_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cur_data
);
  localparam int WORDS = SECTORS * SECT_WORDS;
  logic [WORDS-1:0][DATA_W-1:0] flat;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sect
    for (genvar w = 0; w < SECT_WORDS; w++) begin : g_word
      localparam int IDX = s * SECT_WORDS + w;
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         word_q <= '1;
        else if (erase_en && erase_mask[s])                 word_q <= '1;
        else if (prog_en && prog_addr == ADDR_W'(IDX))      word_q <= word_q & prog_data;
      end
      assign flat[IDX] = word_q;
    end
  end

  assign rd_data  = flat[rd_addr];
  assign cur_data = flat[prog_addr];
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SECTORS     = 4,
  parameter int SECT_WORDS  = 4,
  parameter int WINDOW_CYC  = 5000,
  parameter int PULSE_CYC   = 16,
  parameter int PULSE_LIMIT = 32,
  localparam int ADDR_W     = $clog2(SECTORS * SECT_WORDS),
  localparam int OFF_W      = $clog2(SECT_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               busy,
  output logic               limit_fail,
  output logic               erase_started,
  output logic [SECTORS-1:0] sector_map
);
  fsg_state_e            state_q;
  logic [SECTORS-1:0]    map_q;
  logic [ADDR_W-1:0]     paddr_q;
  logic [DATA_W-1:0]     pdata_q;
  logic [DATA_W-1:0]     cur_data;
  logic                  fire, win_load, win_expire, pulse_clear, pulse_run;
  logic                  tick, last, susp_now, erase_step, prog_step;
  logic [SECTORS-1:0]    sel_onehot, lowest, map_after;
  fsg_op_e               op;

  assign op         = fsg_op_e'(cmd_op);
  assign fire       = cmd_valid && cmd_ready;
  assign sel_onehot = SECTORS'(1) << cmd_addr[ADDR_W-1:OFF_W];
  assign lowest     = map_q & (~map_q + SECTORS'(1));
  assign map_after  = map_q & ~lowest;

  assign win_load    = fire && op == OP_SERASE && (state_q == ST_IDLE || state_q == ST_WIN);
  assign susp_now    = fire && op == OP_SUSP && state_q == ST_ERASE;
  assign pulse_clear = (state_q == ST_IDLE && fire && (op == OP_PROG || op == OP_CERASE))
                     || (state_q == ST_WIN && win_expire);
  assign pulse_run   = state_q == ST_PROG || state_q == ST_ERASE;
  assign prog_step   = state_q == ST_PROG && tick;
  assign erase_step  = state_q == ST_ERASE && tick && !susp_now;

  fsg_win_timer #(.WINDOW_CYC(WINDOW_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .run(state_q == ST_WIN), .expire(win_expire)
  );

  fsg_pulse_timer #(.PULSE_CYC(PULSE_CYC), .PULSE_LIMIT(PULSE_LIMIT)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clear(pulse_clear), .run(pulse_run), .tick(tick), .last(last)
  );

  fsg_array #(.DATA_W(DATA_W), .SECTORS(SECTORS), .SECT_WORDS(SECT_WORDS), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_en(prog_step), .prog_addr(paddr_q), .prog_data(pdata_q),
    .erase_en(erase_step), .erase_mask(lowest),
    .rd_addr(rd_addr), .rd_data(rd_data), .cur_data(cur_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fire) begin
          case (op)
            OP_PROG: begin
              paddr_q <= cmd_addr;
              pdata_q <= cmd_data;
              state_q <= ST_PROG;
            end
            OP_SERASE: begin
              map_q   <= map_q | sel_onehot;
              state_q <= ST_WIN;
            end
            OP_CERASE: begin
              map_q   <= '1;
              state_q <= ST_ERASE;
            end
            default: ;
          endcase
        end
        ST_PROG: if (tick) begin
          if ((pdata_q & ~cur_data) == '0) state_q <= ST_IDLE;
          else if (last)                   state_q <= ST_FAIL;
        end
        ST_WIN: begin
          if (win_load)        map_q   <= map_q | sel_onehot;
          else if (win_expire) state_q <= ST_ERASE;
        end
        ST_ERASE: begin
          if (susp_now) state_q <= ST_SUSP;
          else if (erase_step) begin
            map_q <= map_after;
            if (map_after == '0) state_q <= ST_IDLE;
          end
        end
        ST_SUSP: if (fire && op == OP_RESUME) state_q <= ST_ERASE;
        ST_FAIL: if (fire && op == OP_RESET)  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = state_q != ST_PROG;
  assign busy          = state_q == ST_PROG || state_q == ST_WIN || state_q == ST_ERASE;
  assign limit_fail    = state_q == ST_FAIL;
  assign erase_started = state_q == ST_ERASE || state_q == ST_SUSP;
  assign sector_map    = map_q;
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int SECTORS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2:0]         cmd_op,
  input logic               busy,
  input logic               limit_fail,
  input logic               erase_started,
  input logic [SECTORS-1:0] sector_map
);
  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_fail && !(cmd_valid && cmd_ready && cmd_op == 3'd5)) |=> limit_fail); // R4

  AST_FAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    limit_fail |-> (!busy && !erase_started && sector_map == '0)); // R3

  AST_START_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_started) |-> (busy && sector_map != '0)); // R5

  AST_READY_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> (busy && !erase_started && sector_map == '0)); // R11

  AST_MAP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_started && $past(erase_started)) |-> ((sector_map & ~$past(sector_map)) == '0)); // R7

  AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_started && !busy && $past(erase_started && !busy)) |-> $stable(sector_map)); // R10

  AST_IDLE_MAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !erase_started) |-> sector_map == '0); // R8
endmodule

bind flash_status_gen flash_status_gen_chk #(.SECTORS(SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .busy(busy), .limit_fail(limit_fail), .erase_started(erase_started), .sector_map(sector_map)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  localparam int DW = 8;
  localparam int NS = 4;
  localparam int SW = 4;
  localparam int W  = 40;
  localparam int PC = 4;
  localparam int PL = 6;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic busy, limit_fail, erase_started;
  logic [NS-1:0] sector_map;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .SECTORS(NS), .SECT_WORDS(SW), .WINDOW_CYC(W),
                     .PULSE_CYC(PC), .PULSE_LIMIT(PL)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .limit_fail(limit_fail), .erase_started(erase_started), .sector_map(sector_map)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard driver side: queue an expected array word and wait for the monitor
  task automatic expect_word(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back('{a: a, d: d});
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  initial begin
    forever begin
      wait (exp_q.size() != 0);
      rd_addr = exp_q[0].a;
      #1;
      chk(tag_q[0], 32'(rd_data), 32'(exp_q[0].d));
      exp_q.pop_front();
      tag_q.pop_front();
    end
  end

  // called at a falling edge; returns at the falling edge after the accepting edge
  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = a;
    cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 fail", 32'(limit_fail), 0);
    chk("R1 started", 32'(erase_started), 0);
    chk("R1 map", 32'(sector_map), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    expect_word("R1 word0", 4'd0, 8'hFF);
    expect_word("R1 word15", 4'd15, 8'hFF);

    // R2 / R11 program success
    send(3'd0, 4'd1, 8'hA5);
    chk("R11 ready low in program", 32'(cmd_ready), 0);
    wait_cyc(PC - 1);
    chk("R2 busy before done", 32'(busy), 1);
    wait_cyc(1);
    chk("R2 busy after done", 32'(busy), 0);
    expect_word("R2 word1", 4'd1, 8'hA5);
    send(3'd0, 4'd1, 8'h81);
    wait_cyc(PC);
    chk("R2 second busy", 32'(busy), 0);
    expect_word("R2 word1 second", 4'd1, 8'h81);

    // R3 failure on 0->1
    send(3'd0, 4'd5, 8'h00);
    wait_cyc(PC);
    send(3'd0, 4'd5, 8'h0F);
    wait_cyc(PL * PC - 1);
    chk("R3 fail before limit", 32'(limit_fail), 0);
    chk("R3 busy before limit", 32'(busy), 1);
    wait_cyc(1);
    chk("R3 fail at limit", 32'(limit_fail), 1);
    chk("R3 busy at limit", 32'(busy), 0);
    expect_word("R3 word5", 4'd5, 8'h00);

    // R4 sticky failure, reset
    send(3'd0, 4'd6, 8'h00);
    wait_cyc(PC + 2);
    chk("R4 fail held", 32'(limit_fail), 1);
    expect_word("R4 word6 untouched", 4'd6, 8'hFF);
    send(3'd5, 4'd0, 8'h00);
    chk("R4 fail cleared", 32'(limit_fail), 0);
    chk("R4 busy after reset", 32'(busy), 0);

    // R11 stray suspend in idle
    send(3'd3, 4'd0, 8'h00);
    chk("R11 idle suspend busy", 32'(busy), 0);
    chk("R11 idle suspend started", 32'(erase_started), 0);

    // R5 R6 R7 R8 sector erase with re-armed window
    send(3'd0, 4'd9, 8'h12);
    wait_cyc(PC);
    send(3'd0, 4'd2, 8'h34);
    wait_cyc(PC);
    send(3'd1, 4'd9, 8'h00);
    chk("R5 map", 32'(sector_map), 32'b0100);
    chk("R5 busy", 32'(busy), 1);
    chk("R5 started low", 32'(erase_started), 0);
    wait_cyc(10);
    send(3'd1, 4'd2, 8'h00);
    chk("R6 map grows", 32'(sector_map), 32'b0101);
    wait_cyc(W - 1);
    chk("R6 window restarted", 32'(erase_started), 0);
    wait_cyc(1);
    chk("R5 started after window", 32'(erase_started), 1);
    send(3'd0, 4'd4, 8'h00);
    wait_cyc(PC - 2);
    chk("R8 map before first step", 32'(sector_map), 32'b0101);
    wait_cyc(1);
    chk("R8 lowest sector first", 32'(sector_map), 32'b0100);
    expect_word("R8 word2 erased", 4'd2, 8'hFF);
    expect_word("R8 word9 still programmed", 4'd9, 8'h12);
    wait_cyc(PC);
    chk("R8 map empty", 32'(sector_map), 0);
    chk("R8 busy falls", 32'(busy), 0);
    chk("R8 started falls", 32'(erase_started), 0);
    expect_word("R8 word9 erased", 4'd9, 8'hFF);
    expect_word("R7 word4 ignored program", 4'd4, 8'hFF);

    // R9 R10 chip erase with suspend/resume
    send(3'd0, 4'd13, 8'h0F);
    wait_cyc(PC);
    send(3'd2, 4'd0, 8'h00);
    chk("R9 started at once", 32'(erase_started), 1);
    chk("R9 map full", 32'(sector_map), 32'b1111);
    chk("R9 busy", 32'(busy), 1);
    wait_cyc(PC);
    chk("R9 first sector", 32'(sector_map), 32'b1110);
    send(3'd3, 4'd0, 8'h00);
    chk("R10 suspended busy", 32'(busy), 0);
    chk("R10 suspended started", 32'(erase_started), 1);
    wait_cyc(20);
    chk("R10 map frozen", 32'(sector_map), 32'b1110);
    expect_word("R10 word13 kept", 4'd13, 8'h0F);
    send(3'd4, 4'd0, 8'h00);
    chk("R10 resumed busy", 32'(busy), 1);
    for (int i = 0; i < 100 && busy; i++) wait_cyc(1);
    chk("R10 map done", 32'(sector_map), 0);
    chk("R10 started done", 32'(erase_started), 0);
    expect_word("R10 word13 erased", 4'd13, 8'hFF);

    summary();
    $finish;
  end
endmodule